// File: doc/BRIEF.md
# Priority Port-Pin Crossbar Allocator

This block decides which on-chip peripheral signal owns each of a bank of general-purpose port pins (four 8-bit ports, 32 pins by default). Three 8-bit configuration words hold per-peripheral enable bits. Every enabled signal takes the next free pin, counting upward from pin 0. Signals are visited in a fixed priority list. A signal's pin number therefore depends on how many higher-priority signals are enabled ahead of it. Pins left over after allocation stay plain GPIO.

The block is purely combinational. For every pin it produces a select code that names the owning signal and its direction. It steers peripheral output values and output enables onto the pins and returns pin input values to the peripherals. Serial peripherals claim all of their signals as a group. A three-wire SPI option drops the slave-select signal and closes the gap it leaves.

Top module: `pin_crossbar`

## Requirements
- R1: When cfg0 bit 2 is set, the first UART's transmit signal (index 0) owns pin 0 and its receive signal (index 1) owns pin 1, whatever else is enabled.
- R2: Each enabled signal owns a pin, taken in index order. Pin p belongs to the (p+1)-th enabled signal, counted from the lowest index. Allocation leaves no unused pin below an owned pin.
- R3: Serial peripherals are enabled as groups. cfg0 bit 1 enables SPI indices 2 to 5 (clock, MISO, MOSI, select). cfg0 bit 0 enables the two-wire bus indices 6 (data) and 7 (clock). cfg2 bit 2 enables the second UART indices 8 (tx) and 9 (rx).
- R4: When spi_3w_i is high, signal index 5 (SPI select) receives no pin, and every later enabled signal takes the position one lower than it would otherwise have.
- R5: cfg0 bits 5:3 give a count n of PWM outputs (indices 10 to 15). Outputs 10 to 10+n-1 are enabled, and any count above 6 acts as 6.
- R6: Single-signal enables are as follows. Index 16 (counter clock input) is cfg0 bit 6 and index 17 (comparator 0) is cfg0 bit 7. Index 18 (comparator 1) is cfg1 bit 0. Indices 19 to 24 (timer0 in, irq0 in, timer1 in, irq1 in, timer2 io, timer2 capture) are cfg1 bits 1 to 6. Index 27 (system clock out) is cfg1 bit 7. Indices 25 and 26 (timer4 io, timer4 capture) are cfg2 bits 3 and 4. Indices 28 and 29 (convert-start 0 and 2) are cfg2 bits 0 and 5.
- R7: Each pin's 8-bit select code is {owned, dir[1:0], index[4:0]}. A GPIO pin reads 0x00. Direction codes are 01 output, 10 input and 11 bidirectional. Outputs are indices 0, 8, 10-15, 17, 18 and 27. Bidirectional signals are indices 2-7, 23 and 25. All other indices are inputs.
- R8: On an owned pin, the outputs depend on the signal's direction. For an output signal, pin_out equals the signal's sig_out and pin_oe is 1. For an input signal, pin_out and pin_oe are both 0. For a bidirectional signal, pin_out equals sig_out and pin_oe equals sig_oe.
- R9: A GPIO pin carries latch_i on pin_out and latch_oe_i on pin_oe.
- R10: Each signal that owns a pin reads that pin's pin_in on sig_in. A signal without a pin reads 1, whatever the pins carry.
- R11: Signals whose position would reach NUM_PINS or beyond get no pin. They are left out without any indication.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg0_i | input | 8 | Enable word 0 (serial groups, PWM count, counter clock, comparator 0) |
| cfg1_i | input | 8 | Enable word 1 (comparator 1, timer and interrupt inputs, clock out) |
| cfg2_i | input | 8 | Enable word 2 (second UART, timer4, convert-start) |
| spi_3w_i | input | 1 | SPI three-wire option, drops the select signal |
| sig_out_i | input | 30 | Output value of each peripheral signal |
| sig_oe_i | input | 30 | Output enable of each bidirectional signal |
| sig_in_o | output | 30 | Pin value returned to each peripheral signal |
| pin_in_i | input | NUM_PINS | Input value sampled at each pin |
| latch_i | input | NUM_PINS | Port latch value for GPIO pins |
| latch_oe_i | input | NUM_PINS | Port direction for GPIO pins |
| pin_out_o | output | NUM_PINS | Value driven toward each pin |
| pin_oe_o | output | NUM_PINS | Output enable toward each pin |
| pin_sel_o | output | 8*NUM_PINS | Per-pin select code, pin p at bits 8p+7:8p |

## Verification
The checker assumes that the inputs have settled, because the block has no state and its immediate assertions are evaluated on the combinational result. The checker also assumes that sig_oe_i matters only for bidirectional signals. The bench therefore changes all inputs together half a cycle before it samples. It drives sig_oe_i with arbitrary values on every signal, so that a direction mistake would show on pin_oe. Configuration words come from directed corner cases and from random patterns. The random patterns include PWM counts 7 and above, and the three-wire option with SPI both on and off. A second instance with 16 pins lets the fully enabled set overflow the pin count.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  localparam int SIG_COUNT = 30;
  localparam int SIG_IDX_W = 5;
  localparam int PWM_BASE  = 10;
  localparam int PWM_MAX   = 6;
  localparam int SEL_IDX   = 5;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_OUT  = 2'b01,
    DIR_IN   = 2'b10,
    DIR_BIDI = 2'b11
  } dir_e;

  typedef struct packed {
    logic                 used;
    dir_e                 dir;
    logic [SIG_IDX_W-1:0] id;
  } pin_sel_t;

  // direction of each signal index
  function automatic dir_e sig_dir(input int s);
    if (s == 0 || s == 8 || s == 17 || s == 18 || s == 27) return DIR_OUT;
    if (s >= PWM_BASE && s < PWM_BASE + PWM_MAX) return DIR_OUT;
    if ((s >= 2 && s <= 7) || s == 23 || s == 25) return DIR_BIDI;
    return DIR_IN;
  endfunction

  // saturating PWM output count
  function automatic int pwm_count(input logic [2:0] f);
    return (int'(f) > PWM_MAX) ? PWM_MAX : int'(f);
  endfunction

  // per-signal request vector from the enable words
  function automatic logic [SIG_COUNT-1:0] build_requests(
    input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2,
    input logic three_wire);
    logic [SIG_COUNT-1:0] r;
    int n;
    r = '0;
    n = pwm_count(c0[5:3]);
    r[1:0] = {2{c0[2]}};
    r[4:2] = {3{c0[1]}};
    r[SEL_IDX] = c0[1] & ~three_wire;
    r[7:6] = {2{c0[0]}};
    r[9:8] = {2{c2[2]}};
    for (int k = 0; k < PWM_MAX; k++) r[PWM_BASE+k] = (k < n);
    r[16] = c0[6];
    r[17] = c0[7];
    r[18] = c1[0];
    r[24:19] = c1[6:1];
    r[25] = c2[3];
    r[26] = c2[4];
    r[27] = c1[7];
    r[28] = c2[0];
    r[29] = c2[5];
    return r;
  endfunction
endpackage

// File: rtl/xbar_req_decode.sv
`timescale 1ns/1ps
module xbar_req_decode
  import xbar_pkg::*;
(
  input  logic [7:0]           cfg0_i,
  input  logic [7:0]           cfg1_i,
  input  logic [7:0]           cfg2_i,
  input  logic                 three_wire_i,
  output logic [SIG_COUNT-1:0] req_o
);
  assign req_o = build_requests(cfg0_i, cfg1_i, cfg2_i, three_wire_i);
endmodule

// File: rtl/xbar_rank.sv
`timescale 1ns/1ps
module xbar_rank
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = $clog2(SIG_COUNT + 1)
) (
  input  logic [SIG_COUNT-1:0]            req_i,
  output logic [SIG_COUNT-1:0][CNT_W-1:0] pos_o,
  output logic [SIG_COUNT-1:0]            placed_o
);
  logic [CNT_W-1:0] run;

  // running count of enabled signals ahead of each index
  always_comb begin
    run = '0;
    for (int s = 0; s < SIG_COUNT; s++) begin
      pos_o[s]    = run;
      placed_o[s] = req_i[s] && (int'(run) < NUM_PINS);
      run         = run + CNT_W'(req_i[s]);
    end
  end
endmodule

// File: rtl/xbar_pin_route.sv
`timescale 1ns/1ps
module xbar_pin_route
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = $clog2(SIG_COUNT + 1)
) (
  input  logic [SIG_COUNT-1:0][CNT_W-1:0] pos_i,
  input  logic [SIG_COUNT-1:0]            placed_i,
  input  logic [SIG_COUNT-1:0]            sig_out_i,
  input  logic [SIG_COUNT-1:0]            sig_oe_i,
  input  logic [NUM_PINS-1:0]             latch_i,
  input  logic [NUM_PINS-1:0]             latch_oe_i,
  output pin_sel_t [NUM_PINS-1:0]         sel_o,
  output logic [NUM_PINS-1:0]             pin_out_o,
  output logic [NUM_PINS-1:0]             pin_oe_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_sel_t sel;

    always_comb begin
      sel = '0;
      for (int s = 0; s < SIG_COUNT; s++) begin
        if (placed_i[s] && int'(pos_i[s]) == p) begin
          sel.used = 1'b1;
          sel.dir  = sig_dir(s);
          sel.id   = s[SIG_IDX_W-1:0];
        end
      end
    end

    always_comb begin
      if (!sel.used) begin
        pin_out_o[p] = latch_i[p];
        pin_oe_o[p]  = latch_oe_i[p];
      end else begin
        case (sel.dir)
          DIR_OUT: begin
            pin_out_o[p] = sig_out_i[sel.id];
            pin_oe_o[p]  = 1'b1;
          end
          DIR_BIDI: begin
            pin_out_o[p] = sig_out_i[sel.id];
            pin_oe_o[p]  = sig_oe_i[sel.id];
          end
          default: begin
            pin_out_o[p] = 1'b0;
            pin_oe_o[p]  = 1'b0;
          end
        endcase
      end
    end

    assign sel_o[p] = sel;
  end
endmodule

// File: rtl/xbar_in_route.sv
`timescale 1ns/1ps
module xbar_in_route
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = $clog2(SIG_COUNT + 1)
) (
  input  logic [SIG_COUNT-1:0][CNT_W-1:0] pos_i,
  input  logic [SIG_COUNT-1:0]            placed_i,
  input  logic [NUM_PINS-1:0]             pin_in_i,
  output logic [SIG_COUNT-1:0]            sig_in_o
);
  always_comb begin
    for (int s = 0; s < SIG_COUNT; s++) begin
      sig_in_o[s] = 1'b1;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (placed_i[s] && int'(pos_i[s]) == p) sig_in_o[s] = pin_in_i[p];
      end
    end
  end
endmodule

// File: rtl/pin_crossbar.sv
`timescale 1ns/1ps
module pin_crossbar
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [7:0]                              cfg0_i,
  input  logic [7:0]                              cfg1_i,
  input  logic [7:0]                              cfg2_i,
  input  logic                                    spi_3w_i,
  input  logic [SIG_COUNT-1:0]                    sig_out_i,
  input  logic [SIG_COUNT-1:0]                    sig_oe_i,
  output logic [SIG_COUNT-1:0]                    sig_in_o,
  input  logic [NUM_PINS-1:0]                     pin_in_i,
  input  logic [NUM_PINS-1:0]                     latch_i,
  input  logic [NUM_PINS-1:0]                     latch_oe_i,
  output logic [NUM_PINS-1:0]                     pin_out_o,
  output logic [NUM_PINS-1:0]                     pin_oe_o,
  output logic [NUM_PINS*$bits(pin_sel_t)-1:0]    pin_sel_o
);
  localparam int CNT_W = $clog2(SIG_COUNT + 1);

  logic [SIG_COUNT-1:0]            req;
  logic [SIG_COUNT-1:0][CNT_W-1:0] pos;
  logic [SIG_COUNT-1:0]            placed;
  pin_sel_t [NUM_PINS-1:0]         sel_vec;

  xbar_req_decode u_dec (
    .cfg0_i      (cfg0_i),
    .cfg1_i      (cfg1_i),
    .cfg2_i      (cfg2_i),
    .three_wire_i(spi_3w_i),
    .req_o       (req)
  );

  xbar_rank #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_rank (
    .req_i   (req),
    .pos_o   (pos),
    .placed_o(placed)
  );

  xbar_pin_route #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_pins (
    .pos_i     (pos),
    .placed_i  (placed),
    .sig_out_i (sig_out_i),
    .sig_oe_i  (sig_oe_i),
    .latch_i   (latch_i),
    .latch_oe_i(latch_oe_i),
    .sel_o     (sel_vec),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o)
  );

  xbar_in_route #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_ins (
    .pos_i   (pos),
    .placed_i(placed),
    .pin_in_i(pin_in_i),
    .sig_in_o(sig_in_o)
  );

  assign pin_sel_o = sel_vec;
endmodule

// File: rtl/xbar_chk.sv
`timescale 1ns/1ps
module xbar_chk
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                                 u0_en,
  input logic                                 three_wire,
  input logic [NUM_PINS*$bits(pin_sel_t)-1:0] sel_flat,
  input logic [NUM_PINS-1:0]                  pin_in,
  input logic [NUM_PINS-1:0]                  pin_out,
  input logic [NUM_PINS-1:0]                  pin_oe,
  input logic [NUM_PINS-1:0]                  latch,
  input logic [NUM_PINS-1:0]                  latch_oe,
  input logic [SIG_COUNT-1:0]                 sig_out,
  input logic [SIG_COUNT-1:0]                 sig_oe,
  input logic [SIG_COUNT-1:0]                 sig_in
);
  localparam int W = $bits(pin_sel_t);
  pin_sel_t cur;
  pin_sel_t prev;

  always_comb begin
    cur  = '0;
    prev = '0;
    if (u0_en) begin
      // R1
      uart0_pins_chk: assert (sel_flat[W-1:0] == {1'b1, DIR_OUT, 5'd0} &&
                              sel_flat[2*W-1:W] == {1'b1, DIR_IN, 5'd1})
        else $error("first UART not on pins 0 and 1");
    end
    for (int p = 0; p < NUM_PINS; p++) begin
      cur = sel_flat[p*W +: W];
      if (p > 0) begin
        prev = sel_flat[(p-1)*W +: W];
        // R2
        dense_fill_chk: assert (!cur.used || (prev.used && prev.id < cur.id))
          else $error("pin %0d owned above a gap or out of order", p);
      end
      // R4
      nss_drop_chk: assert (!(three_wire && cur.used && cur.id == SEL_IDX[SIG_IDX_W-1:0]))
        else $error("select signal placed in three-wire mode");
      if (!cur.used) begin
        // R9
        gpio_pass_chk: assert (cur == '0 && pin_out[p] == latch[p] && pin_oe[p] == latch_oe[p])
          else $error("GPIO pin %0d not driven from latch", p);
      end else begin
        // R8
        out_steer_chk: assert ((cur.dir == DIR_OUT  && pin_oe[p] && pin_out[p] == sig_out[cur.id]) ||
                               (cur.dir == DIR_IN   && !pin_oe[p] && !pin_out[p]) ||
                               (cur.dir == DIR_BIDI && pin_oe[p] == sig_oe[cur.id] &&
                                pin_out[p] == sig_out[cur.id]))
          else $error("pin %0d steering wrong", p);
        // R10
        in_steer_chk: assert (sig_in[cur.id] == pin_in[p])
          else $error("signal %0d not reading pin %0d", cur.id, p);
      end
    end
  end
endmodule

bind pin_crossbar xbar_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .u0_en     (cfg0_i[2]),
  .three_wire(spi_3w_i),
  .sel_flat  (pin_sel_o),
  .pin_in    (pin_in_i),
  .pin_out   (pin_out_o),
  .pin_oe    (pin_oe_o),
  .latch     (latch_i),
  .latch_oe  (latch_oe_i),
  .sig_out   (sig_out_i),
  .sig_oe    (sig_oe_i),
  .sig_in    (sig_in_o)
);

// File: tb/pin_crossbar_tb_top.sv
`timescale 1ns/1ps
module pin_crossbar_tb_top;
  localparam int NP  = 32;
  localparam int NPS = 16;
  localparam int NS  = 30;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic [7:0] cfg0, cfg1, cfg2;
  logic w3;
  logic [NS-1:0] sig_out, sig_oe, sig_in, sm_sig_in;
  logic [NP-1:0] pin_in, latch, latch_oe, pin_out, pin_oe;
  logic [NPS-1:0] sm_pin_out, sm_pin_oe;
  logic [NP*8-1:0] pin_sel;
  logic [NPS*8-1:0] sm_pin_sel;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [7:0] exp_sel [NP];
  int exp_pin [NS];

  pin_crossbar dut_i (
    .cfg0_i(cfg0), .cfg1_i(cfg1), .cfg2_i(cfg2), .spi_3w_i(w3),
    .sig_out_i(sig_out), .sig_oe_i(sig_oe), .sig_in_o(sig_in),
    .pin_in_i(pin_in), .latch_i(latch), .latch_oe_i(latch_oe),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .pin_sel_o(pin_sel));

  pin_crossbar #(.NUM_PINS(NPS)) small_i (
    .cfg0_i(cfg0), .cfg1_i(cfg1), .cfg2_i(cfg2), .spi_3w_i(w3),
    .sig_out_i(sig_out), .sig_oe_i(sig_oe), .sig_in_o(sm_sig_in),
    .pin_in_i(pin_in[NPS-1:0]), .latch_i(latch[NPS-1:0]), .latch_oe_i(latch_oe[NPS-1:0]),
    .pin_out_o(sm_pin_out), .pin_oe_o(sm_pin_oe), .pin_sel_o(sm_pin_sel));

  // direction codes per R7
  function automatic logic [1:0] ref_dir(input int s);
    case (s)
      0, 8, 10, 11, 12, 13, 14, 15, 17, 18, 27: return 2'b01;
      2, 3, 4, 5, 6, 7, 23, 25:                 return 2'b11;
      default:                                  return 2'b10;
    endcase
  endfunction

  // enable decode per R3..R6
  function automatic bit ref_en(input int s);
    int n;
    if (s <= 1) return cfg0[2];
    if (s <= 4) return cfg0[1];
    if (s == 5) return cfg0[1] && !w3;
    if (s <= 7) return cfg0[0];
    if (s <= 9) return cfg2[2];
    if (s <= 15) begin
      n = (cfg0[5:3] > 3'd6) ? 6 : int'(cfg0[5:3]);
      return (s - 10) < n;
    end
    case (s)
      16: return cfg0[6];
      17: return cfg0[7];
      18: return cfg1[0];
      25: return cfg2[3];
      26: return cfg2[4];
      27: return cfg1[7];
      28: return cfg2[0];
      29: return cfg2[5];
      default: return cfg1[s-18];
    endcase
  endfunction

  task automatic build_exp(input int npins);
    int ptr = 0;
    for (int p = 0; p < NP; p++) exp_sel[p] = 8'h00;
    for (int s = 0; s < NS; s++) begin
      exp_pin[s] = -1;
      if (ref_en(s) && ptr < npins) begin
        exp_sel[ptr] = {1'b1, ref_dir(s), 5'(s)};
        exp_pin[s] = ptr;
        ptr++;
      end
    end
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic exp_drive(input int p, output logic o, output logic e);
    int id;
    if (!exp_sel[p][7]) begin
      o = latch[p]; e = latch_oe[p];
    end else begin
      id = int'(exp_sel[p][4:0]);
      case (exp_sel[p][6:5])
        2'b01:   begin o = sig_out[id]; e = 1'b1; end
        2'b11:   begin o = sig_out[id]; e = sig_oe[id]; end
        default: begin o = 1'b0; e = 1'b0; end
      endcase
    end
  endtask

  task automatic check_all(input string req);
    logic o, e;
    build_exp(NP);
    for (int p = 0; p < NP; p++) begin
      check(req, $sformatf("sel pin%0d", p), 32'(pin_sel[p*8 +: 8]), 32'(exp_sel[p]));
      exp_drive(p, o, e);
      check(req, $sformatf("out/oe pin%0d", p), {30'd0, pin_out[p], pin_oe[p]}, {30'd0, o, e});
    end
    for (int s = 0; s < NS; s++)
      check(req, $sformatf("sig_in %0d", s), 32'(sig_in[s]),
            32'((exp_pin[s] >= 0) ? pin_in[exp_pin[s]] : 1'b1));
    build_exp(NPS);
    for (int p = 0; p < NPS; p++) begin
      check(req, $sformatf("small sel pin%0d", p), 32'(sm_pin_sel[p*8 +: 8]), 32'(exp_sel[p]));
      exp_drive(p, o, e);
      check(req, $sformatf("small out/oe pin%0d", p), {30'd0, sm_pin_out[p], sm_pin_oe[p]},
            {30'd0, o, e});
    end
    for (int s = 0; s < NS; s++)
      check(req, $sformatf("small sig_in %0d", s), 32'(sm_sig_in[s]),
            32'((exp_pin[s] >= 0) ? pin_in[exp_pin[s]] : 1'b1));
  endtask

  task automatic set_data(input logic [NS-1:0] so, input logic [NS-1:0] soe,
                          input logic [NP-1:0] pi, input logic [NP-1:0] la,
                          input logic [NP-1:0] lo);
    sig_out = so; sig_oe = soe; pin_in = pi; latch = la; latch_oe = lo;
  endtask

  task automatic apply(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2,
                       input logic w);
    @(negedge clk);
    cfg0 = c0; cfg1 = c1; cfg2 = c2; w3 = w;
    @(posedge clk);
    #5;
  endtask

  task automatic rand_data();
    set_data(NS'($urandom), NS'($urandom), $urandom, $urandom, $urandom);
  endtask

  task automatic t_reset();
    set_data('0, '0, 32'hFFFF_0000, 32'hA5A5_5A5A, 32'h0F0F_F0F0);
    apply(8'h00, 8'h00, 8'h00, 1'b0);
    for (int p = 0; p < NP; p++)
      check("R9", $sformatf("idle pin%0d", p), {23'd0, pin_sel[p*8 +: 8], pin_out[p]},
            {23'd0, 8'h00, latch[p]});
    check_all("R9");
  endtask

  task automatic t_uart0();
    rand_data();
    apply(8'h04, 8'h00, 8'h00, 1'b0);
    check("R1", "pin0", 32'(pin_sel[7:0]), 32'hA0);
    check("R1", "pin1", 32'(pin_sel[15:8]), 32'hC1);
    check_all("R1");
    apply(8'hFF, 8'hFF, 8'hFF, 1'b1);
    check("R1", "pin0 full", 32'(pin_sel[7:0]), 32'hA0);
    check("R1", "pin1 full", 32'(pin_sel[15:8]), 32'hC1);
  endtask

  task automatic t_groups();
    rand_data();
    apply(8'h02, 8'h00, 8'h00, 1'b0);
    check("R3", "spi", 32'(pin_sel[39:0]), 32'hE5E4E3E2);
    check("R3", "spi pin4", 32'(pin_sel[39:32]), 32'h00);
    check_all("R3");
    apply(8'h01, 8'h00, 8'h00, 1'b0);
    check("R3", "two-wire", 32'(pin_sel[23:0]), 32'h00E7E6);
    apply(8'h00, 8'h00, 8'h04, 1'b0);
    check("R3", "uart1", 32'(pin_sel[23:0]), 32'h00C9A8);
    check_all("R3");
  endtask

  task automatic t_three_wire();
    rand_data();
    apply(8'h07, 8'h00, 8'h00, 1'b1);
    check("R4", "pins0-3", pin_sel[31:0], 32'hE3E2C1A0);
    check("R4", "pins4-7", pin_sel[63:32], 32'h00E7E6E4);
    check_all("R4");
    apply(8'h01, 8'h00, 8'h00, 1'b1);
    check("R4", "spi off", 32'(pin_sel[15:0]), 32'hE7E6);
    apply(8'h07, 8'h00, 8'h00, 1'b0);
    check("R4", "four-wire", pin_sel[63:32], 32'hE7E6E5E4);
  endtask

  task automatic t_pwm();
    int n;
    for (int f = 0; f < 8; f++) begin
      rand_data();
      apply(8'(f << 3), 8'h00, 8'h00, 1'b0);
      n = (f > 6) ? 6 : f;
      for (int p = 0; p < 8; p++)
        check("R5", $sformatf("count%0d pin%0d", f, p), 32'(pin_sel[p*8 +: 8]),
              (p < n) ? 32'(8'hAA + 8'(p)) : 32'h00);
    end
    check_all("R5");
  endtask

  task automatic t_single();
    int ids1 [8] = '{18, 19, 20, 21, 22, 23, 24, 27};
    int bits2 [4] = '{0, 3, 4, 5};
    int ids2 [4] = '{28, 25, 26, 29};
    for (int b = 0; b < 8; b++) begin
      apply(8'h00, 8'(1 << b), 8'h00, 1'b0);
      check("R6", $sformatf("cfg1 bit%0d", b), 32'(pin_sel[4:0]), 32'(ids1[b]));
      check("R6", $sformatf("cfg1 bit%0d pin1", b), 32'(pin_sel[15:8]), 32'h00);
    end
    for (int k = 0; k < 4; k++) begin
      apply(8'h00, 8'h00, 8'(1 << bits2[k]), 1'b0);
      check("R6", $sformatf("cfg2 bit%0d", bits2[k]), 32'(pin_sel[4:0]), 32'(ids2[k]));
    end
    apply(8'h40, 8'h00, 8'h00, 1'b0);
    check("R6", "cfg0 bit6", 32'(pin_sel[4:0]), 32'd16);
    apply(8'h80, 8'h00, 8'h00, 1'b0);
    check("R6", "cfg0 bit7", 32'(pin_sel[4:0]), 32'd17);
    check_all("R6");
  endtask

  task automatic t_code();
    apply(8'h00, 8'h20, 8'h00, 1'b0);
    check("R7", "timer2 bidir", 32'(pin_sel[7:0]), 32'hF7);
    apply(8'h80, 8'h00, 8'h00, 1'b0);
    check("R7", "comparator out", 32'(pin_sel[7:0]), 32'hB1);
    apply(8'h00, 8'h02, 8'h00, 1'b0);
    check("R7", "timer0 in", 32'(pin_sel[7:0]), 32'hD3);
  endtask

  task automatic t_steer();
    set_data(30'h2AAA_AAAA, 30'h1555_5555, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0);
    apply(8'hF7, 8'hFF, 8'h3D, 1'b0);
    check("R8", "pin0 tx", {30'd0, pin_out[0], pin_oe[0]}, {30'd0, sig_out[0], 1'b1});
    check("R8", "pin1 rx", {30'd0, pin_out[1], pin_oe[1]}, 32'd0);
    check("R8", "pin2 bidir", {30'd0, pin_out[2], pin_oe[2]}, {30'd0, sig_out[2], sig_oe[2]});
    check_all("R8");
    set_data(30'h0, 30'h0, 32'h0, 32'h0, 32'h0);
    apply(8'h04, 8'h00, 8'h00, 1'b0);
    check("R10", "disabled spi clk reads 1", 32'(sig_in[2]), 32'd1);
    set_data(30'h0, 30'h0, 32'h0000_0002, 32'h0, 32'h0);
    apply(8'h04, 8'h00, 8'h00, 1'b0);
    check("R10", "rx reads pin1", 32'(sig_in[1]), 32'd1);
    check("R10", "unplaced stays 1", 32'(sig_in[29]), 32'd1);
    rand_data();
    apply(8'h13, 8'h5A, 8'h24, 1'b0);
    check_all("R10");
  endtask

  task automatic t_overflow();
    set_data('0, '0, 32'h0, 32'h0, 32'h0);
    apply(8'hF7, 8'hFF, 8'h3D, 1'b0);
    check("R11", "small pin15", 32'(sm_pin_sel[127:120]), 32'hAF);
    check("R11", "small sig16 unplaced", 32'(sm_sig_in[16]), 32'd1);
    check("R11", "small sig29 unplaced", 32'(sm_sig_in[29]), 32'd1);
    check("R11", "full pin29", 32'(pin_sel[239:232]), 32'hDD);
    check("R11", "full pin30 gpio", 32'(pin_sel[247:240]), 32'h00);
    check_all("R11");
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      rand_data();
      apply(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
      check_all("R2");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg0 = '0; cfg1 = '0; cfg2 = '0; w3 = 1'b0;
    set_data('0, '0, '0, '0, '0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_uart0();
    t_groups();
    t_three_wire();
    t_pwm();
    t_single();
    t_code();
    t_steer();
    t_overflow();
    t_random();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule